// File: doc/BRIEF.md
# Device-interleaved quad SECDED memory protection

This block guards a wide memory word stored in DRAM devices that are four bits wide each. The data side carries four 64-bit lanes. Each lane becomes its own single-error-correcting, double-error-detecting codeword of 72 bits: 64 data bits, seven Hamming check bits and one overall parity bit. The four codewords are then bit-interleaved across the devices. Each device holds exactly one bit of every codeword, so if a whole device fails, each codeword sees at most one bad bit, and all four codewords can repair it.

The write path is purely combinational. It takes the 256-bit write word and produces the 288-bit device-side word. On the read path the device-side word is presented together with a valid strobe. One clock later the block returns the repaired 256-bit word, a corrected flag and an uncorrectable flag for each lane, and a halt-request interrupt that is raised whenever any lane could not be repaired.

Top module: `chip_ileave_ecc`

## Requirements
- R1: Codeword layout for lane k, which carries data bits wr_data[64k+63:64k]:
  - Bit 0 is the overall parity, chosen so that all 72 bits XOR to zero.
  - Bits 1, 2, 4, 8, 16, 32 and 64 hold the Hamming checks. Check bit 2^r is the XOR of every other position p in 1..71 whose binary bit r is set.
  - Data bit j sits at the j-th position in 3..71, counted in ascending order, that is not a power of two.
  - On the device side, bit 4d+b carries position d of lane b's codeword.
- R2: A read word with no errors returns all four lanes unchanged, with every corrected and uncorrectable flag low and nmi_o low.
- R3: A single flipped bit anywhere in one lane's codeword is repaired. This includes a flip of the parity bit at position 0. That lane's corrected flag is set, and its uncorrectable flag is clear.
- R4: Two flipped bits in the same lane's codeword set that lane's uncorrectable flag and leave its corrected flag clear. The other lanes are unaffected.
- R5: Any nonzero pattern of flipped bits within one device (device-side bits 4d..4d+3) is fully repaired. The corrected flag is set for exactly the lanes whose bit was hit, and no uncorrectable flag is raised.
- R6: nmi_o is high in a result cycle exactly when at least one lane's uncorrectable flag is high.
- R7: Results appear in the cycle after rd_valid_i is sampled high, with rd_valid_o high.
  - In cycles where rd_valid_o is low, all flags and nmi_o are low and rd_data holds its previous value.
  - Back-to-back reads produce back-to-back results.
- R8: While rst_n is low, rd_valid_o, rd_data, all flags and nmi_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 256 | Write data, four 64-bit lanes |
| mem_wdata | output | 288 | Encoded, interleaved word toward the devices |
| rd_valid_i | input | 1 | Read word present on mem_rdata |
| mem_rdata | input | 288 | Interleaved word read from the devices |
| rd_valid_o | output | 1 | Result valid, one cycle after rd_valid_i |
| rd_data | output | 256 | Repaired read data |
| corr_o | output | 4 | Per-lane corrected-error flag |
| uncorr_o | output | 4 | Per-lane uncorrectable-error flag |
| nmi_o | output | 1 | Halt request, high when any lane is uncorrectable |

## Verification
The embedded properties check the following on every cycle:
- the one-cycle valid latency;
- that the corrected and uncorrectable flags of a lane are never high together;
- that no flag or interrupt appears without a result;
- that the interrupt is backed by an uncorrectable lane;
- that read data holds during idle cycles.

Whether data is actually repaired, and whether the right lane is flagged, is shown only by the bench's scenarios: clean words, random single flips, parity-bit flips, same-lane double flips, mixed lanes and whole-device faults, each checked against an expectation built from the injected pattern. The exact bit placement of the write path is likewise shown only by comparing against an independently built encoding.

// File: rtl/chip_ileave_pkg.sv
package chip_ileave_pkg;
   localparam int MAX_CW = 1024;

   // number of Hamming check bits for a data width
   function automatic int ham_bits(input int dw);
      int r;
      r = 1;
      while ((1 << r) < dw + r + 1) r = r + 1;
      return r;
   endfunction

   // codeword position of data bit k: k-th non-power-of-two position from 3
   function automatic int data_pos(input int k);
      int cnt;
      int pos;
      cnt = 0;
      pos = 0;
      for (int p = 3; p < MAX_CW; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (cnt == k && pos == 0) pos = p;
            cnt++;
         end
      end
      return pos;
   endfunction

   // positions covered by check bit 2^r
   function automatic logic [MAX_CW-1:0] cover_mask(input int r, input int cw_w);
      logic [MAX_CW-1:0] m;
      m = '0;
      for (int p = 1; p < MAX_CW; p++)
         if (p < cw_w && ((p >> r) & 1) == 1) m[p] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/chip_ileave_enc.sv
module chip_ileave_enc
   import chip_ileave_pkg::*;
#(
   parameter int DATA_W = 64,
   localparam int R    = ham_bits(DATA_W),
   localparam int CW_W = DATA_W + R + 1
) (
   input  logic [DATA_W-1:0] data_i,
   output wire  [CW_W-1:0]   cw_o
);
   wire [CW_W-1:1] spread;
   wire [R-1:0]    chk;

   for (genvar j = 0; j < DATA_W; j++) begin : g_data
      localparam int POS = data_pos(j);
      assign spread[POS] = data_i[j];
      assign cw_o[POS]   = data_i[j];
   end

   for (genvar r = 0; r < R; r++) begin : g_chk
      localparam logic [MAX_CW-1:0] MF = cover_mask(r, CW_W);
      localparam logic [CW_W-1:1]   M  = MF[CW_W-1:1];
      assign spread[1 << r] = 1'b0;
      assign chk[r]         = ^(spread & M);
      assign cw_o[1 << r]   = chk[r];
   end

   assign cw_o[0] = ^{chk, data_i};
endmodule

// File: rtl/chip_ileave_dec.sv
module chip_ileave_dec
   import chip_ileave_pkg::*;
#(
   parameter int DATA_W = 64,
   localparam int R    = ham_bits(DATA_W),
   localparam int CW_W = DATA_W + R + 1
) (
   input  logic [CW_W-1:0]   cw_i,
   output wire  [DATA_W-1:0] data_o,
   output logic              corr_o,
   output logic              uncorr_o
);
   wire  [R-1:0] syn;
   logic         par;
   logic         in_range;

   for (genvar r = 0; r < R; r++) begin : g_syn
      localparam logic [MAX_CW-1:0] MF = cover_mask(r, CW_W);
      localparam logic [CW_W-1:1]   M  = MF[CW_W-1:1];
      assign syn[r] = ^(cw_i[CW_W-1:1] & M);
   end

   always_comb begin
      par      = ^cw_i;
      in_range = {1'b0, syn} < (R + 1)'(CW_W);
      corr_o   = par && in_range;
      uncorr_o = ((|syn) && !par) || (par && !in_range);
   end

   for (genvar j = 0; j < DATA_W; j++) begin : g_fix
      localparam int POS = data_pos(j);
      assign data_o[j] = cw_i[POS] ^ (corr_o && (syn == R'(POS)));
   end
endmodule

// File: rtl/chip_ileave_ecc.sv
module chip_ileave_ecc
   import chip_ileave_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int DEV_W  = 4,
   localparam int LANES = DEV_W,
   localparam int R     = ham_bits(DATA_W),
   localparam int CW_W  = DATA_W + R + 1,
   localparam int NDEV  = CW_W,
   localparam int MEM_W = NDEV * DEV_W,
   localparam int BUS_W = LANES * DATA_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BUS_W-1:0] wr_data,
   output wire  [MEM_W-1:0] mem_wdata,
   input  logic             rd_valid_i,
   input  logic [MEM_W-1:0] mem_rdata,
   output logic             rd_valid_o,
   output logic [BUS_W-1:0] rd_data,
   output logic [LANES-1:0] corr_o,
   output logic [LANES-1:0] uncorr_o,
   output logic             nmi_o
);
   if (DEV_W < 2) begin : g_bad_dev
      $error("DEV_W must be at least 2");
   end
   if (DATA_W < 4) begin : g_bad_data
      $error("DATA_W must be at least 4");
   end
   if (CW_W > MAX_CW) begin : g_bad_cw
      $error("codeword wider than MAX_CW");
   end

   wire [BUS_W-1:0] dec_data;
   wire [LANES-1:0] dec_corr;
   wire [LANES-1:0] dec_unc;

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      wire [CW_W-1:0] cw_w;
      wire [CW_W-1:0] cw_r;

      chip_ileave_enc #(.DATA_W(DATA_W)) u_enc (
         .data_i (wr_data[b*DATA_W +: DATA_W]),
         .cw_o   (cw_w)
      );

      for (genvar d = 0; d < NDEV; d++) begin : g_dev
         assign mem_wdata[d*DEV_W + b] = cw_w[d];
         assign cw_r[d]                = mem_rdata[d*DEV_W + b];
      end

      chip_ileave_dec #(.DATA_W(DATA_W)) u_dec (
         .cw_i     (cw_r),
         .data_o   (dec_data[b*DATA_W +: DATA_W]),
         .corr_o   (dec_corr[b]),
         .uncorr_o (dec_unc[b])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_o <= 1'b0;
         rd_data    <= '0;
         corr_o     <= '0;
         uncorr_o   <= '0;
         nmi_o      <= 1'b0;
      end else begin
         rd_valid_o <= rd_valid_i;
         if (rd_valid_i) begin
            rd_data  <= dec_data;
            corr_o   <= dec_corr;
            uncorr_o <= dec_unc;
            nmi_o    <= |dec_unc;
         end else begin
            corr_o   <= '0;
            uncorr_o <= '0;
            nmi_o    <= 1'b0;
         end
      end
   end

   assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o == $past(rd_valid_i));

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid_i |=> $stable(rd_data));

   assert_flags_need_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((|corr_o) || (|uncorr_o) || nmi_o) |-> rd_valid_o);

   assert_flag_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (corr_o & uncorr_o) == '0);

   assert_nmi_backed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_o |-> (|uncorr_o));
endmodule

// File: tb/tb_chip_ileave_ecc.sv
`timescale 1ns/1ps
module tb_chip_ileave_ecc;
   localparam int DW = 64;
   localparam int LN = 4;
   localparam int CW = 72;
   localparam int MW = CW * LN;
   localparam int BW = DW * LN;

   typedef struct {
      logic [BW-1:0] data;
      logic [LN-1:0] corr;
      logic [LN-1:0] unc;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [BW-1:0] wr_data = '0;
   wire  [MW-1:0] mem_wdata;
   logic          rd_valid_i = 1'b0;
   logic [MW-1:0] mem_rdata = '0;
   logic          rd_valid_o;
   logic [BW-1:0] rd_data;
   logic [LN-1:0] corr_o;
   logic [LN-1:0] uncorr_o;
   logic          nmi_o;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   exp_t expq[$];
   logic [BW-1:0] last_data = '0;

   always #2 clk = ~clk;

   chip_ileave_ecc dut (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .mem_wdata(mem_wdata),
      .rd_valid_i(rd_valid_i), .mem_rdata(mem_rdata), .rd_valid_o(rd_valid_o),
      .rd_data(rd_data), .corr_o(corr_o), .uncorr_o(uncorr_o), .nmi_o(nmi_o)
   );

   task automatic ck(input bit ok, input string tag, input logic [MW-1:0] act,
                     input logic [MW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [CW-1:0] ref_cw(input logic [DW-1:0] d);
      logic [CW-1:0] c;
      int k;
      bit par;
      c = '0;
      k = 0;
      for (int p = 1; p < CW; p++)
         if ((p & (p - 1)) != 0) begin
            c[p] = d[k];
            k++;
         end
      for (int r = 0; r < 7; r++) begin
         par = 0;
         for (int p = 1; p < CW; p++)
            if (((p >> r) & 1) == 1) par ^= c[p];
         c[1 << r] = par;
      end
      c[0] = ^c;
      return c;
   endfunction

   function automatic logic [MW-1:0] ileave(input logic [BW-1:0] d);
      logic [MW-1:0] m;
      logic [CW-1:0] c;
      for (int b = 0; b < LN; b++) begin
         c = ref_cw(d[b*DW +: DW]);
         for (int dv = 0; dv < CW; dv++) m[4*dv + b] = c[dv];
      end
      return m;
   endfunction

   function automatic logic [BW-1:0] rnd_word();
      logic [BW-1:0] w;
      for (int i = 0; i < BW / 32; i++) w[i*32 +: 32] = $urandom;
      return w;
   endfunction

   task automatic issue(input logic [MW-1:0] m, input logic [BW-1:0] d,
                        input logic [LN-1:0] c, input logic [LN-1:0] u, input string t);
      exp_t e;
      @(negedge clk);
      mem_rdata  = m;
      rd_valid_i = 1'b1;
      e.data = d; e.corr = c; e.unc = u; e.tag = t;
      expq.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rd_valid_i = 1'b0;
         mem_rdata  = rnd_word() << 32;
      end
   endtask

   // result checker, every negedge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (rd_valid_o) begin
            if (expq.size() == 0) begin
               ck(0, "R7 unexpected result", MW'(rd_valid_o), '0);
            end else begin
               exp_t e;
               logic [BW-1:0] mask;
               e = expq.pop_front();
               mask = '0;
               for (int b = 0; b < LN; b++)
                  if (!e.unc[b]) mask[b*DW +: DW] = '1;
               ck((rd_data & mask) == (e.data & mask), {e.tag, " data"},
                  MW'(rd_data & mask), MW'(e.data & mask));
               ck(corr_o == e.corr, {e.tag, " corr"}, MW'(corr_o), MW'(e.corr));
               ck(uncorr_o == e.unc, {e.tag, " uncorr"}, MW'(uncorr_o), MW'(e.unc));
               ck(nmi_o == (|e.unc), "R6 nmi", MW'(nmi_o), MW'(|e.unc));
            end
            last_data = rd_data;
         end else begin
            ck(corr_o == '0 && uncorr_o == '0 && !nmi_o, "R7 idle flags",
               MW'({corr_o, uncorr_o, nmi_o}), '0);
            ck(rd_data == last_data, "R7 idle hold", MW'(rd_data), MW'(last_data));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [BW-1:0] d;
      logic [MW-1:0] m;
      int idx, dv, d2, ln;
      logic [LN-1:0] msk;

      repeat (3) @(negedge clk);
      // R8 reset state
      ck(!rd_valid_o && rd_data == '0 && corr_o == '0 && uncorr_o == '0 && !nmi_o,
         "R8 reset", MW'({rd_valid_o, corr_o, uncorr_o, nmi_o, rd_data}), '0);
      rst_n = 1'b1;

      // R1 write path layout
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         d = (i == 0) ? '0 : (i == 1) ? '1 : rnd_word();
         wr_data = d;
         #1;
         ck(mem_wdata == ileave(d), "R1 encode", mem_wdata, ileave(d));
      end

      // R2 clean reads, back to back
      for (int i = 0; i < 8; i++) begin
         d = rnd_word();
         issue(ileave(d), d, '0, '0, "R2 clean");
      end
      idle(2);

      // R3 random single-bit errors
      for (int i = 0; i < 40; i++) begin
         d = rnd_word();
         idx = $urandom_range(MW - 1);
         m = ileave(d);
         m[idx] = ~m[idx];
         issue(m, d, LN'(1) << (idx % 4), '0, "R3 single");
         if (i % 3 == 0) idle(1);
      end
      // R3 parity bit (position 0) of every lane
      for (int b = 0; b < LN; b++) begin
         d = rnd_word();
         m = ileave(d);
         m[b] = ~m[b];
         issue(m, d, LN'(1) << b, '0, "R3 parity bit");
      end
      idle(2);

      // R4 double errors in one lane
      for (int i = 0; i < 30; i++) begin
         d = rnd_word();
         ln = $urandom_range(LN - 1);
         dv = $urandom_range(CW - 1);
         d2 = (dv + 1 + $urandom_range(CW - 2)) % CW;
         m = ileave(d);
         m[4*dv + ln] = ~m[4*dv + ln];
         m[4*d2 + ln] = ~m[4*d2 + ln];
         issue(m, d, '0, LN'(1) << ln, "R4 double");
         if (i % 4 == 0) idle(1);
      end
      // R4 single in lane 0 plus double in lane 2
      d = rnd_word();
      m = ileave(d);
      m[4*5] = ~m[4*5];
      m[4*7 + 2] = ~m[4*7 + 2];
      m[4*60 + 2] = ~m[4*60 + 2];
      issue(m, d, 4'b0001, 4'b0100, "R4 mixed lanes");
      idle(2);

      // R5 whole-device faults
      for (int i = 0; i < 40; i++) begin
         d = rnd_word();
         dv = (i < 2) ? i * (CW - 1) : $urandom_range(CW - 1);
         msk = (i % 2 == 0) ? 4'hF : LN'($urandom_range(14) + 1);
         m = ileave(d);
         for (int b = 0; b < LN; b++)
            if (msk[b]) m[4*dv + b] = ~m[4*dv + b];
         issue(m, d, msk, '0, "R5 device fault");
         if (i % 5 == 0) idle(1);
      end
      idle(4);

      finished = 1;
      ck(expq.size() == 0, "R7 results drained", MW'(expq.size()), '0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule